// File: doc/BRIEF.md
# ATA LBA Sector Read Sequencer

This block fetches a single sector from an ATA device that is addressed by a 28-bit logical block address. It does not generate bus strobes. Each device register access is handed to a separate register-access engine through a request/done handshake. The sequencer decides which register to touch, what to write, and how to interpret what comes back.

When a read is requested, the block first reads the device status. While the status still shows data pending from an earlier sector, it discards words by reading the Data register. It then waits until the device reports that it can accept a command. Next it writes the seven command-block registers. After that it polls status until the device offers data, raises sector-available and loads the word counter.

A consumer elsewhere takes the words and reports each one on `word_take`. An error bit in the status, or a poll that never resolves, leads to recovery. The block raises its external error output, runs a device soft reset and leaves only the error flag set. After power-up the block waits, resets the device and lets it settle before it accepts any request.

Top module: `ata_sector_reader`

## Requirements
- R1: While `rst` is high (synchronous, active high), the outputs are as follows. `acc_req`, `ready`, `rd_done`, `err_o`, all four status flags and `words_left` are 0.
- R2: After reset the block waits at least POWERUP_CYC cycles. It then writes 0x04 to the device-control register (access address 4'hE) and waits at least SRST_HOLD_CYC cycles. It then writes 0x00 to the same register, waits at least SETTLE_CYC cycles and raises `ready`. No other access occurs in this phase.
- R3: Register access addresses are 0=Data, 1=Feature, 2=SectorCount, 3/4/5=LBA bits 7:0/15:8/23:16, 6=Drive/Head, 7=Command (write) or Status (read). The command phase writes these in a fixed order: Feature 0x00, SectorCount 0x01, LBA[7:0], LBA[15:8], LBA[23:16], Drive/Head, and finally Command 0x20.
- R4: The Drive/Head value is LBA[27:24] with bits 7, 6 and 5 forced to 1 and bit 4 (drive select) 0, i.e. `{4'hE, lba[27:24]}`.
- R5: Each status byte read updates the flags as follows, with the first rule taking priority:
  - (status & 0xC9) == 0x48 sets `st_xfer_ok` and clears `st_cmd_ok`.
  - Otherwise, (status & 0xC1) == 0x40 sets `st_cmd_ok` and clears `st_xfer_ok`.
  - Otherwise both flags keep their values.
  
  The two flags are never both set.
- R6: Before the command phase, a status with bit 3 (DRQ) set and bit 0 clear causes one Data register read, followed by a fresh status read. This repeats until DRQ is clear.
- R7: No command register is written until a pre-command status read yields `st_cmd_ok`. Until then the status is read repeatedly.
- R8: After the Command write, status is polled until `st_xfer_ok`. The block then sets `st_sect_avail`, loads `words_left` with WORDS_PER_SECT-1, pulses `rd_done` for one cycle and returns to `ready`.
- R9: A status with bit 0 (ERR) set triggers error recovery. `err_o` and `st_error` go high, and the other flags clear. The device-control soft reset of R2 runs without the settle wait. `err_o` then drops, `rd_done` pulses, and only `st_error` remains set until the next accepted request.
- R10: A status read that completes POLL_LIMIT or more cycles after the request was accepted, or after the Command write, triggers the recovery of R9 if it resolves neither to command-allowed (pre-command) nor to data-ready (poll).
- R11: Only one register access is outstanding at a time. `acc_req`, `acc_we`, `acc_addr` and `acc_wdata` stay stable from the rise of `acc_req` until `acc_done`.
- R12: `rd_req` is accepted only while `ready` is high. At other times it causes no register access.
- R13: Each `word_take` while `st_sect_avail` is set either decrements `words_left` or, when it is already 0, clears `st_sect_avail`. A `word_take` while `st_sect_avail` is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Start a sector read (taken when ready) |
| rd_lba | input | 28 | Logical block address of the sector |
| ready | output | 1 | Idle and able to accept a request |
| rd_done | output | 1 | One-cycle pulse when a request ends (success or error) |
| acc_req | output | 1 | Register access request to the bus engine |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_addr | output | 4 | Register select: bit 3 chooses the control block, bits 2:0 the register |
| acc_wdata | output | 8 | Write data |
| acc_done | input | 1 | Access completion from the bus engine |
| acc_rdata | input | 8 | Read data, valid with acc_done |
| word_take | input | 1 | One sector word consumed |
| words_left | output | 8 | Remaining words minus one |
| st_error | output | 1 | Error flag |
| st_xfer_ok | output | 1 | Device offers data |
| st_cmd_ok | output | 1 | Device accepts a command |
| st_sect_avail | output | 1 | Sector data ready to be taken |
| err_o | output | 1 | External error indication during recovery |

## Verification
The assertions rely on the bus engine behaving in a particular way. It answers each outstanding request with exactly one `acc_done` pulse, never raises `acc_done` with no request pending, and presents `acc_rdata` in the same cycle as `acc_done`. The bench engine model enforces this: it accepts a request only when idle, answers after a fixed latency, and takes a status byte from a per-scenario script. The stability properties on the request therefore hold only against an engine that does not complete early or twice. Requests arriving while not ready are deliberately driven, because the properties do not assume they are absent.

// File: rtl/ata_rd_pkg.sv
package ata_rd_pkg;

  localparam int LBA_W   = 28;
  localparam int REG_AW  = 4;
  localparam int N_STEPS = 7;
  localparam int STEP_W  = $clog2(N_STEPS);

  // register select: bit 3 = control block, bits 2:0 = register
  localparam logic [REG_AW-1:0] RA_DATA    = 4'h0;
  localparam logic [REG_AW-1:0] RA_FEAT    = 4'h1;
  localparam logic [REG_AW-1:0] RA_SCNT    = 4'h2;
  localparam logic [REG_AW-1:0] RA_LBA_LO  = 4'h3;
  localparam logic [REG_AW-1:0] RA_LBA_MID = 4'h4;
  localparam logic [REG_AW-1:0] RA_LBA_HI  = 4'h5;
  localparam logic [REG_AW-1:0] RA_DEVHEAD = 4'h6;
  localparam logic [REG_AW-1:0] RA_CMDSTAT = 4'h7;
  localparam logic [REG_AW-1:0] RA_DEVCTL  = 4'hE;

  localparam logic [7:0] FEAT_VAL      = 8'h00;
  localparam logic [7:0] SCNT_VAL      = 8'h01;
  localparam logic [7:0] CMD_RD_SECT   = 8'h20;
  localparam logic [7:0] DEVHEAD_FIXED = 8'hE0;
  localparam logic [7:0] CTL_SRST      = 8'h04;
  localparam logic [7:0] CTL_RUN       = 8'h00;

  localparam logic [7:0] MSK_XFER = 8'hC9;
  localparam logic [7:0] VAL_XFER = 8'h48;
  localparam logic [7:0] MSK_CMD  = 8'hC1;
  localparam logic [7:0] VAL_CMD  = 8'h40;
  localparam int ERR_BIT = 0;
  localparam int DRQ_BIT = 3;

  typedef enum logic [3:0] {
    S_PWRUP, S_RST_ON, S_RST_HOLD, S_RST_OFF, S_SETTLE,
    S_IDLE, S_PRE_STAT, S_DRAIN, S_CMD, S_POLL, S_FAIL
  } seq_state_e;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [7:0]        data;
  } reg_wr_t;

endpackage

// File: rtl/ata_cmd_step.sv
module ata_cmd_step
  import ata_rd_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [LBA_W-1:0]  lba,
  output reg_wr_t           wr
);

  always_comb begin
    unique case (step)
      3'd0:    wr = '{addr: RA_FEAT,    data: FEAT_VAL};
      3'd1:    wr = '{addr: RA_SCNT,    data: SCNT_VAL};
      3'd2:    wr = '{addr: RA_LBA_LO,  data: lba[7:0]};
      3'd3:    wr = '{addr: RA_LBA_MID, data: lba[15:8]};
      3'd4:    wr = '{addr: RA_LBA_HI,  data: lba[23:16]};
      3'd5:    wr = '{addr: RA_DEVHEAD, data: DEVHEAD_FIXED | {4'h0, lba[27:24]}};
      default: wr = '{addr: RA_CMDSTAT, data: CMD_RD_SECT};
    endcase
  end

endmodule

// File: rtl/ata_stat_decode.sv
module ata_stat_decode
  import ata_rd_pkg::*;
(
  input  logic [7:0] status,
  input  logic       xfer_in,
  input  logic       cmd_in,
  output logic       xfer_out,
  output logic       cmd_out,
  output logic       err_hit,
  output logic       drq
);

  always_comb begin
    xfer_out = xfer_in;
    cmd_out  = cmd_in;
    err_hit  = status[ERR_BIT];
    drq      = status[DRQ_BIT];
    if ((status & MSK_XFER) == VAL_XFER) begin
      xfer_out = 1'b1;
      cmd_out  = 1'b0;
    end else if ((status & MSK_CMD) == VAL_CMD) begin
      xfer_out = 1'b0;
      cmd_out  = 1'b1;
    end
  end

endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= W'(RST_VAL);
    else if (load)        cnt <= value;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ata_sector_reader.sv
module ata_sector_reader
  import ata_rd_pkg::*;
#(
  parameter int POWERUP_CYC    = 3100,
  parameter int SRST_HOLD_CYC  = 12240,
  parameter int SETTLE_CYC     = 9300,
  parameter int POLL_LIMIT     = 1 << 20,
  parameter int WORDS_PER_SECT = 256,
  localparam int WC_W          = $clog2(WORDS_PER_SECT)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [LBA_W-1:0]  rd_lba,
  output logic              ready,
  output logic              rd_done,
  output logic              acc_req,
  output logic              acc_we,
  output logic [REG_AW-1:0] acc_addr,
  output logic [7:0]        acc_wdata,
  input  logic              acc_done,
  input  logic [7:0]        acc_rdata,
  input  logic              word_take,
  output logic [WC_W-1:0]   words_left,
  output logic              st_error,
  output logic              st_xfer_ok,
  output logic              st_cmd_ok,
  output logic              st_sect_avail,
  output logic              err_o
);

  localparam int DLY_MAX0 = (POWERUP_CYC > SRST_HOLD_CYC) ? POWERUP_CYC : SRST_HOLD_CYC;
  localparam int DLY_MAX  = (DLY_MAX0 > SETTLE_CYC) ? DLY_MAX0 : SETTLE_CYC;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int TMO_W    = $clog2(POLL_LIMIT + 1);
  localparam logic [STEP_W-1:0] LAST_STEP   = STEP_W'(N_STEPS - 1);
  localparam logic [WC_W-1:0]   WORD_RELOAD = WC_W'(WORDS_PER_SECT - 1);

  seq_state_e        state;
  logic              acc_busy;
  logic [STEP_W-1:0] step;
  logic [LBA_W-1:0]  lba_q;
  logic              xfer_q, cmd_q, sect_q, err_q, err_out_q;
  logic              from_err, ready_q, done_q;
  logic [WC_W-1:0]   words_q;

  logic              acc_fin;
  logic              dly_load, dly_exp, tmo_load, tmo_exp;
  logic [DLY_W-1:0]  dly_val;
  reg_wr_t           wr_step;
  logic              dec_xfer, dec_cmd, dec_err, dec_drq;

  assign acc_fin = acc_busy & acc_done;

  ata_cmd_step u_step (
    .step (step),
    .lba  (lba_q),
    .wr   (wr_step)
  );

  ata_stat_decode u_dec (
    .status   (acc_rdata),
    .xfer_in  (xfer_q),
    .cmd_in   (cmd_q),
    .xfer_out (dec_xfer),
    .cmd_out  (dec_cmd),
    .err_hit  (dec_err),
    .drq      (dec_drq)
  );

  always_comb begin
    dly_load = 1'b0;
    dly_val  = DLY_W'(SRST_HOLD_CYC);
    if (state == S_RST_ON && acc_fin) begin
      dly_load = 1'b1;
    end else if (state == S_RST_OFF && acc_fin && !from_err) begin
      dly_load = 1'b1;
      dly_val  = DLY_W'(SETTLE_CYC);
    end
  end

  assign tmo_load = (state == S_IDLE && rd_req) ||
                    (state == S_CMD && acc_fin && step == LAST_STEP);

  ata_wait_timer #(.W(DLY_W), .RST_VAL(POWERUP_CYC)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .load    (dly_load),
    .value   (dly_val),
    .expired (dly_exp)
  );

  ata_wait_timer #(.W(TMO_W), .RST_VAL(0)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .load    (tmo_load),
    .value   (TMO_W'(POLL_LIMIT)),
    .expired (tmo_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PWRUP;
      acc_busy  <= 1'b0;
      acc_we    <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      step      <= '0;
      lba_q     <= '0;
      xfer_q    <= 1'b0;
      cmd_q     <= 1'b0;
      sect_q    <= 1'b0;
      err_q     <= 1'b0;
      err_out_q <= 1'b0;
      from_err  <= 1'b0;
      ready_q   <= 1'b0;
      done_q    <= 1'b0;
      words_q   <= '0;
    end else begin
      done_q <= 1'b0;

      if (word_take && sect_q) begin
        if (words_q == '0) sect_q  <= 1'b0;
        else               words_q <= words_q - 1'b1;
      end

      unique case (state)
        S_PWRUP: if (dly_exp) state <= S_RST_ON;

        S_RST_ON: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b1;
            acc_addr  <= RA_DEVCTL;
            acc_wdata <= CTL_SRST;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            state    <= S_RST_HOLD;
          end
        end

        S_RST_HOLD: if (dly_exp) state <= S_RST_OFF;

        S_RST_OFF: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b1;
            acc_addr  <= RA_DEVCTL;
            acc_wdata <= CTL_RUN;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            if (from_err) begin
              from_err  <= 1'b0;
              err_out_q <= 1'b0;
              done_q    <= 1'b1;
              ready_q   <= 1'b1;
              state     <= S_IDLE;
            end else begin
              state <= S_SETTLE;
            end
          end
        end

        S_SETTLE: begin
          if (dly_exp) begin
            ready_q <= 1'b1;
            state   <= S_IDLE;
          end
        end

        S_IDLE: begin
          if (rd_req) begin
            lba_q   <= rd_lba;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            sect_q  <= 1'b0;
            words_q <= '0;
            state   <= S_PRE_STAT;
          end
        end

        S_PRE_STAT: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b0;
            acc_addr  <= RA_CMDSTAT;
            acc_wdata <= '0;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            xfer_q   <= dec_xfer;
            cmd_q    <= dec_cmd;
            if (dec_err)      state <= S_FAIL;
            else if (dec_drq) state <= S_DRAIN;
            else if (dec_cmd) begin
              step  <= '0;
              state <= S_CMD;
            end else if (tmo_exp) state <= S_FAIL;
          end
        end

        S_DRAIN: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b0;
            acc_addr  <= RA_DATA;
            acc_wdata <= '0;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            state    <= S_PRE_STAT;
          end
        end

        S_CMD: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b1;
            acc_addr  <= wr_step.addr;
            acc_wdata <= wr_step.data;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            if (step == LAST_STEP) state <= S_POLL;
            else                   step  <= step + 1'b1;
          end
        end

        S_POLL: begin
          if (!acc_busy) begin
            acc_busy  <= 1'b1;
            acc_we    <= 1'b0;
            acc_addr  <= RA_CMDSTAT;
            acc_wdata <= '0;
          end else if (acc_done) begin
            acc_busy <= 1'b0;
            xfer_q   <= dec_xfer;
            cmd_q    <= dec_cmd;
            if (dec_err) state <= S_FAIL;
            else if (dec_xfer) begin
              sect_q  <= 1'b1;
              words_q <= WORD_RELOAD;
              done_q  <= 1'b1;
              ready_q <= 1'b1;
              state   <= S_IDLE;
            end else if (tmo_exp) state <= S_FAIL;
          end
        end

        S_FAIL: begin
          err_out_q <= 1'b1;
          err_q     <= 1'b1;
          xfer_q    <= 1'b0;
          cmd_q     <= 1'b0;
          sect_q    <= 1'b0;
          from_err  <= 1'b1;
          state     <= S_RST_ON;
        end

        default: state <= S_PWRUP;
      endcase
    end
  end

  assign ready         = ready_q;
  assign rd_done       = done_q;
  assign acc_req       = acc_busy;
  assign words_left    = words_q;
  assign st_error      = err_q;
  assign st_xfer_ok    = xfer_q;
  assign st_cmd_ok     = cmd_q;
  assign st_sect_avail = sect_q;
  assign err_o         = err_out_q;

endmodule

// File: rtl/ata_sector_reader_chk.sv
module ata_sector_reader_chk #(
  parameter int WORDS = 256,
  localparam int WC_W = $clog2(WORDS)
)(
  input logic            clk,
  input logic            rst,
  input logic            ready,
  input logic            rd_done,
  input logic            acc_req,
  input logic            acc_we,
  input logic [3:0]      acc_addr,
  input logic [7:0]      acc_wdata,
  input logic            acc_done,
  input logic [WC_W-1:0] words_left,
  input logic            st_error,
  input logic            st_xfer_ok,
  input logic            st_cmd_ok,
  input logic            st_sect_avail,
  input logic            err_o
);

  p_acc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_done) |=> (acc_req && $stable(acc_addr) && $stable(acc_we) && $stable(acc_wdata)));

  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(st_xfer_ok && st_cmd_ok));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  p_sect_words_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(st_sect_avail) |-> (words_left == WC_W'(WORDS - 1)));

  p_err_only_r9: assert property (@(posedge clk) disable iff (rst)
    st_error |-> (!st_xfer_ok && !st_cmd_ok && !st_sect_avail));

  p_errout_flag_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> st_error);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    ready |-> !acc_req);

endmodule

bind ata_sector_reader ata_sector_reader_chk #(.WORDS(WORDS_PER_SECT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ready         (ready),
  .rd_done       (rd_done),
  .acc_req       (acc_req),
  .acc_we        (acc_we),
  .acc_addr      (acc_addr),
  .acc_wdata     (acc_wdata),
  .acc_done      (acc_done),
  .words_left    (words_left),
  .st_error      (st_error),
  .st_xfer_ok    (st_xfer_ok),
  .st_cmd_ok     (st_cmd_ok),
  .st_sect_avail (st_sect_avail),
  .err_o         (err_o)
);

// File: tb/ata_sector_reader_bench.sv
module ata_sector_reader_bench;

  localparam int PWR = 20, HOLD = 30, SETTLE = 15, TMO = 150, LAT = 2;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic        rd_req = 1'b0;
  logic [27:0] rd_lba = '0;
  logic        ready, rd_done, acc_req, acc_we;
  logic [3:0]  acc_addr;
  logic [7:0]  acc_wdata;
  logic        acc_done = 1'b0;
  logic [7:0]  acc_rdata = 8'h00;
  logic        word_take = 1'b0;
  logic [7:0]  words_left;
  logic        st_error, st_xfer_ok, st_cmd_ok, st_sect_avail, err_o;

  ata_sector_reader #(
    .POWERUP_CYC(PWR), .SRST_HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE),
    .POLL_LIMIT(TMO), .WORDS_PER_SECT(256)
  ) u_ata_sector_reader (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_lba(rd_lba), .ready(ready),
    .rd_done(rd_done), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .word_take(word_take), .words_left(words_left), .st_error(st_error),
    .st_xfer_ok(st_xfer_ok), .st_cmd_ok(st_cmd_ok), .st_sect_avail(st_sect_avail),
    .err_o(err_o)
  );

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  // bus engine and device model
  logic [7:0] scr [16];
  int         scr_len = 1, scr_idx = 0;
  logic       log_we   [64];
  logic [3:0] log_addr [64];
  logic [7:0] log_dat  [64];
  int         log_cyc  [64];
  int         log_n = 0, stat_rd = 0, data_rd = 0, hold_bad = 0;
  logic       eng_busy = 1'b0;
  int         eng_wait = 0;
  logic [3:0] eng_addr = '0;
  logic [7:0] eng_wd = '0;

  always @(negedge clk) begin
    acc_done = 1'b0;
    if (rst) begin
      eng_busy = 1'b0;
    end else if (eng_busy) begin
      if (!acc_req || acc_addr !== eng_addr || acc_wdata !== eng_wd) hold_bad++;
      if (eng_wait > 0) eng_wait--;
      else begin
        eng_busy = 1'b0;
        acc_done = 1'b1;
        if (log_n < 64) begin
          log_we[log_n] = acc_we; log_addr[log_n] = acc_addr;
          log_dat[log_n] = acc_wdata; log_cyc[log_n] = cyc;
        end
        log_n++;
        if (!acc_we) begin
          if (acc_addr == 4'h7) begin
            acc_rdata = scr[(scr_idx < scr_len) ? scr_idx : scr_len - 1];
            scr_idx++; stat_rd++;
          end else begin
            acc_rdata = 8'h00;
            if (acc_addr == 4'h0) data_rd++;
          end
        end
      end
    end else if (acc_req) begin
      eng_busy = 1'b1; eng_wait = LAT; eng_addr = acc_addr; eng_wd = acc_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lim);
    n_tests++;
    if (act < lim) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected at least %0d", tag, act, lim);
    end
  endtask

  task automatic exp_acc(input int i, input logic we, input logic [3:0] a,
                         input logic [7:0] d, input string tag);
    if (we) chk(tag, {log_we[i], log_addr[i], log_dat[i]}, {we, a, d});
    else    chk(tag, {log_we[i], log_addr[i]}, {we, a});
  endtask

  task automatic exp_cmd(input int base, input logic [27:0] lba);
    exp_acc(base + 0, 1'b1, 4'h1, 8'h00, "R3 feature");
    exp_acc(base + 1, 1'b1, 4'h2, 8'h01, "R3 count");
    exp_acc(base + 2, 1'b1, 4'h3, lba[7:0], "R3 lba lo");
    exp_acc(base + 3, 1'b1, 4'h4, lba[15:8], "R3 lba mid");
    exp_acc(base + 4, 1'b1, 4'h5, lba[23:16], "R3 lba hi");
    exp_acc(base + 5, 1'b1, 4'h6, {4'hE, lba[27:24]}, "R4 drive/head");
    exp_acc(base + 6, 1'b1, 4'h7, 8'h20, "R3 command");
  endtask

  task automatic set_script(input logic [7:0] s0, s1, s2, s3, input int len);
    scr[0] = s0; scr[1] = s1; scr[2] = s2; scr[3] = s3;
    scr_len = len; scr_idx = 0; log_n = 0; stat_rd = 0; data_rd = 0;
  endtask

  bit err_seen;
  task automatic start_and_wait(input logic [27:0] lba);
    @(negedge clk); rd_lba = lba; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    err_seen = 1'b0;
    for (int i = 0; i < 5000 && !rd_done; i++) begin
      @(negedge clk);
      if (err_o) err_seen = 1'b1;
    end
    chk("R8 rd_done seen", rd_done, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs",
        {ready, rd_done, acc_req, err_o, st_error, st_xfer_ok, st_cmd_ok, st_sect_avail},
        8'h00);
    chk("R1 words", words_left, 0);
  endtask

  task automatic t_powerup();
    int rdy_cyc;
    set_script(8'h50, 8'h50, 8'h50, 8'h50, 1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    rd_lba = 28'h1234567; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    for (int i = 0; i < 1000 && !ready; i++) @(negedge clk);
    rdy_cyc = cyc;
    chk("R2 ready after power-up", ready, 1);
    chk("R2/R12 access count", log_n, 2);
    exp_acc(0, 1'b1, 4'hE, 8'h04, "R2 reset on");
    exp_acc(1, 1'b1, 4'hE, 8'h00, "R2 reset off");
    chk_ge("R2 power-up wait", log_cyc[0], PWR);
    chk_ge("R2 reset hold", log_cyc[1] - log_cyc[0], HOLD);
    chk_ge("R2 settle", rdy_cyc - log_cyc[1], SETTLE);
    chk("R12 no status read before ready", stat_rd, 0);
  endtask

  task automatic t_read();
    set_script(8'h50, 8'h80, 8'h80, 8'h58, 4);
    start_and_wait(28'hA3C12F7);
    exp_acc(0, 1'b0, 4'h7, 8'h00, "R7 pre status");
    exp_cmd(1, 28'hA3C12F7);
    chk("R8 poll count", stat_rd, 4);
    chk("R8 access count", log_n, 11);
    chk("R5 flags after 0x58", {st_xfer_ok, st_cmd_ok}, 2'b10);
    chk("R8 sector avail", st_sect_avail, 1);
    chk("R8 words reload", words_left, 255);
    chk("R8 no error", {st_error, err_o}, 0);
  endtask

  task automatic t_words();
    @(negedge clk); word_take = 1'b1;
    repeat (255) @(negedge clk);
    word_take = 1'b0;
    chk("R13 words drained", words_left, 0);
    chk("R13 still avail", st_sect_avail, 1);
    word_take = 1'b1; @(negedge clk); word_take = 1'b0;
    chk("R13 last word clears avail", st_sect_avail, 0);
    word_take = 1'b1; @(negedge clk); word_take = 1'b0;
    chk("R13 take ignored when empty", {st_sect_avail, words_left}, 0);
  endtask

  task automatic t_drain();
    set_script(8'h58, 8'h58, 8'h50, 8'h58, 4);
    start_and_wait(28'h0000042);
    exp_acc(0, 1'b0, 4'h7, 8'h00, "R6 status 1");
    exp_acc(1, 1'b0, 4'h0, 8'h00, "R6 data read 1");
    exp_acc(2, 1'b0, 4'h7, 8'h00, "R6 status 2");
    exp_acc(3, 1'b0, 4'h0, 8'h00, "R6 data read 2");
    exp_acc(4, 1'b0, 4'h7, 8'h00, "R6 status 3");
    exp_cmd(5, 28'h0000042);
    chk("R6 drain count", data_rd, 2);
    chk("R6 access count", log_n, 13);
  endtask

  task automatic t_wait_cmd();
    set_script(8'h80, 8'hD0, 8'h50, 8'h58, 4);
    @(negedge clk); rd_lba = 28'hF00FF00; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    for (int i = 0; i < 500 && stat_rd < 2; i++) @(negedge clk);
    @(negedge clk);
    chk("R5 flags unchanged by 0x80/0xD0", {st_xfer_ok, st_cmd_ok}, 2'b10);
    for (int i = 0; i < 5000 && !rd_done; i++) @(negedge clk);
    chk("R8 done", rd_done, 1);
    exp_acc(0, 1'b0, 4'h7, 8'h00, "R7 status busy");
    exp_acc(1, 1'b0, 4'h7, 8'h00, "R7 status not ready");
    exp_acc(2, 1'b0, 4'h7, 8'h00, "R7 status ready");
    exp_cmd(3, 28'hF00FF00);
  endtask

  task automatic t_err();
    set_script(8'h50, 8'h51, 8'h51, 8'h51, 2);
    start_and_wait(28'h0ABCDEF);
    chk("R9 err_o raised", err_seen, 1);
    chk("R9 err_o released", err_o, 0);
    chk("R9 error-only flags",
        {st_error, st_xfer_ok, st_cmd_ok, st_sect_avail}, 4'b1000);
    chk("R9 access count", log_n, 11);
    exp_acc(9, 1'b1, 4'hE, 8'h04, "R9 reset on");
    exp_acc(10, 1'b1, 4'hE, 8'h00, "R9 reset off");
    chk_ge("R9 reset hold", log_cyc[10] - log_cyc[9], HOLD);
  endtask

  task automatic t_timeout();
    set_script(8'h50, 8'h80, 8'h80, 8'h80, 2);
    start_and_wait(28'h0000001);
    chk("R9 error cleared on new request then set", st_error, 1);
    chk("R10 timeout error", err_seen, 1);
    exp_acc(log_n - 2, 1'b1, 4'hE, 8'h04, "R10 reset on");
    exp_acc(log_n - 1, 1'b1, 4'hE, 8'h00, "R10 reset off");
    chk_ge("R10 poll window", log_cyc[log_n - 2] - log_cyc[7], TMO);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_powerup();
    t_read();
    t_words();
    t_drain();
    t_wait_cmd();
    t_err();
    t_timeout();
    chk("R11 request held until done", hold_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule